// File: doc/BRIEF.md
# Byte-Lane Memory Mode Decoder

This block is the control core of a 16-bit word memory with two byte lanes. It takes two chip selects of opposite polarity, an output enable, a write enable and one enable per byte lane, and turns them into an operating mode: standby, output disabled, read or write. From that mode it produces a drive enable for each data byte, the read data of the enabled lanes, a standby flag, and one write strobe per lane into a byte-wide register array whose depth is a parameter.

The control pins are sampled on every rising clock edge, and all outputs follow the latest sample. A write is treated as a window. It is open for as long as the sample shows the device selected, write enable low and at least one lane enabled. It closes on the first sample where any of these conditions stops holding. A two-state controller keeps the window. In state IDLE the transition "open" is taken when a window sample arrives. In state OPEN the transition "hold" keeps the state while the window stays active. The transition "close" returns to IDLE on the first non-window sample, and in that cycle it fires the lane strobes. The stored value is the address, data and lane set of the last sample inside the window. It lands in the array at the clock edge that ends the closing cycle, so a read sampled at that same edge already returns it.

Top module: `lane_ram_ctrl`

## Requirements
- R1: The device is in standby when the active-low select is 1, or the active-high select is 0, or both lane enables are 1. Standby shows standby_o=1, mode_o=0, both drive enables 0 and rdata_o=0. A write attempted in standby leaves the array unchanged.
- R2: When the device is selected with write enable 1 and output enable 1, mode_o=1 (output disabled), standby_o=0, and neither lane is driven.
- R3: When the device is selected with write enable 1 and output enable 0, mode_o=2 (read). Lane 0 is bits 7:0 and is enabled by lo_en_n_i=0. Lane 1 is bits 15:8 and is enabled by hi_en_n_i=0. Each enabled lane asserts its drive enable and shows its stored byte. A lane that is not enabled shows 0 and is not driven.
- R4: A write changes only the lanes that are enabled in the last sample of its window. Output enable has no effect on a write.
- R5: The write window closes on the first sample in which select, write enable or the lane enables go inactive. The address and data of the last window sample are stored. A read in the sample after the closing sample returns the new value, and the closing sample itself still shows the old value.
- R6: While the device is selected with write enable 0 and a lane enabled, mode_o=3 (write), and neither lane is driven, whatever the state of output enable.
- R7: Outputs reflect the controls sampled at the latest rising clock edge. After reset the block is in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_i | input | 1 | Active-low chip select |
| sel_i | input | 1 | Active-high chip select |
| oe_n_i | input | 1 | Active-low output enable |
| we_n_i | input | 1 | Active-low write enable |
| lo_en_n_i | input | 1 | Active-low enable for lane 0 (bits 7:0) |
| hi_en_n_i | input | 1 | Active-low enable for lane 1 (bits 15:8) |
| addr_i | input | AW | Word address, AW = clog2(DEPTH) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data of the driven lanes, 0 elsewhere |
| drv_lo_o | output | 1 | Drive enable for bits 7:0 |
| drv_hi_o | output | 1 | Drive enable for bits 15:8 |
| standby_o | output | 1 | Standby (deselect) status |
| mode_o | output | 2 | 0 standby, 1 output disabled, 2 read, 3 write |

## Verification
The hardest case to reach is a write window that spans several samples while its contents keep changing. The stimulus opens a window, changes data, address or lane set from one sample to the next, and closes it in turn by write enable, by either select and by both lanes going inactive. Reads then show which sample's values were kept. A read placed directly in the closing sample, and another placed directly after it, pin down the one-cycle commit point. Write attempts in each standby condition, followed by reads of the targeted word, show that those attempts are ignored.

// File: rtl/lrc_pkg.sv
package lrc_pkg;

    localparam int LRC_LANES = 2;

    typedef enum logic [1:0] {
        MODE_STANDBY = 2'd0,
        MODE_OUT_OFF = 2'd1,
        MODE_READ    = 2'd2,
        MODE_WRITE   = 2'd3
    } lrc_mode_e;

    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_OPEN = 1'b1
    } lrc_win_e;

    typedef struct packed {
        logic                 sel_n;
        logic                 sel;
        logic                 oe_n;
        logic                 we_n;
        logic [LRC_LANES-1:0] lane_n;
    } lrc_ctl_t;

endpackage

// File: rtl/lrc_mode_dec.sv
module lrc_mode_dec
    import lrc_pkg::*;
(
    input  lrc_ctl_t             ctl,
    output lrc_mode_e            mode,
    output logic                 standby,
    output logic                 win,
    output logic [LRC_LANES-1:0] drv
);

    logic selected;

    always_comb begin
        selected = !ctl.sel_n && ctl.sel && (ctl.lane_n != '1);
        standby  = !selected;
        unique case ({selected, ctl.we_n, ctl.oe_n})
            3'b100, 3'b101: mode = MODE_WRITE;
            3'b110:         mode = MODE_READ;
            3'b111:         mode = MODE_OUT_OFF;
            default:        mode = MODE_STANDBY;
        endcase
        win = (mode == MODE_WRITE);
    end

    for (genvar g = 0; g < LRC_LANES; g++) begin : g_drv
        assign drv[g] = (mode == MODE_READ) && !ctl.lane_n[g];
    end

endmodule

// File: rtl/lrc_win_fsm.sv
module lrc_win_fsm
    import lrc_pkg::*;
#(
    parameter int AW     = 10,
    parameter int BYTE_W = 8,
    localparam int DW    = BYTE_W * LRC_LANES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 win,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        wdata,
    input  logic [LRC_LANES-1:0] lane_n,
    output logic [LRC_LANES-1:0] wstb,
    output logic [AW-1:0]        w_addr,
    output logic [DW-1:0]        w_data
);

    lrc_win_e              state;
    lrc_win_e              nxt;
    logic                  commit;
    logic [LRC_LANES-1:0]  h_lane;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WIN_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt    = state;
        commit = 1'b0;
        unique case (state)
            WIN_IDLE: begin
                if (win) begin
                    nxt = WIN_OPEN;
                end
            end
            WIN_OPEN: begin
                if (!win) begin
                    nxt    = WIN_IDLE;
                    commit = 1'b1;
                end
            end
            default: nxt = WIN_IDLE;
        endcase
        wstb = commit ? h_lane : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_addr <= '0;
            w_data <= '0;
            h_lane <= '0;
        end else if (win) begin
            w_addr <= addr;
            w_data <= wdata;
            h_lane <= ~lane_n;
        end
    end

endmodule

// File: rtl/lrc_lane_bank.sv
module lrc_lane_bank #(
    parameter int DEPTH  = 1024,
    parameter int BYTE_W = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic [AW-1:0]     raddr,
    output logic [BYTE_W-1:0] rbyte
);

    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wbyte;
        end
    end

    assign rbyte = mem[raddr];

endmodule

// File: rtl/lane_ram_ctrl.sv
module lane_ram_ctrl
    import lrc_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int BYTE_W = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int DW    = BYTE_W * LRC_LANES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_n_i,
    input  logic          sel_i,
    input  logic          oe_n_i,
    input  logic          we_n_i,
    input  logic          lo_en_n_i,
    input  logic          hi_en_n_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          drv_lo_o,
    output logic          drv_hi_o,
    output logic          standby_o,
    output logic [1:0]    mode_o
);

    lrc_ctl_t              s_ctl;
    logic [AW-1:0]         s_addr;
    logic [DW-1:0]         s_wdata;
    lrc_mode_e             mode;
    logic                  win;
    logic [LRC_LANES-1:0]  drv;
    logic [LRC_LANES-1:0]  wstb;
    logic [AW-1:0]         w_addr;
    logic [DW-1:0]         w_data;

    // Sampling stage: every output follows the latest sampled controls.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_ctl   <= '{sel_n: 1'b1, sel: 1'b0, oe_n: 1'b1, we_n: 1'b1, lane_n: '1};
            s_addr  <= '0;
            s_wdata <= '0;
        end else begin
            s_ctl   <= '{sel_n: sel_n_i, sel: sel_i, oe_n: oe_n_i, we_n: we_n_i,
                         lane_n: {hi_en_n_i, lo_en_n_i}};
            s_addr  <= addr_i;
            s_wdata <= wdata_i;
        end
    end

    lrc_mode_dec i_dec (
        .ctl     (s_ctl),
        .mode    (mode),
        .standby (standby_o),
        .win     (win),
        .drv     (drv)
    );

    lrc_win_fsm #(
        .AW     (AW),
        .BYTE_W (BYTE_W)
    ) i_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .win    (win),
        .addr   (s_addr),
        .wdata  (s_wdata),
        .lane_n (s_ctl.lane_n),
        .wstb   (wstb),
        .w_addr (w_addr),
        .w_data (w_data)
    );

    for (genvar g = 0; g < LRC_LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] rbyte;

        lrc_lane_bank #(
            .DEPTH  (DEPTH),
            .BYTE_W (BYTE_W)
        ) i_bank (
            .clk   (clk),
            .we    (wstb[g]),
            .waddr (w_addr),
            .wbyte (w_data[g*BYTE_W +: BYTE_W]),
            .raddr (s_addr),
            .rbyte (rbyte)
        );

        assign rdata_o[g*BYTE_W +: BYTE_W] = drv[g] ? rbyte : '0;
    end

    assign drv_lo_o = drv[0];
    assign drv_hi_o = drv[1];
    assign mode_o   = mode;

endmodule

// File: rtl/lrc_checker.sv
module lrc_checker
    import lrc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       standby,
    input logic [1:0] drv,
    input logic [1:0] wstb
);

    // R1: standby never drives a lane
    assert_standby_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> (drv == 2'b00 && mode == MODE_STANDBY));

    // R2: output-disabled mode is active but silent
    assert_out_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OUT_OFF) |-> (drv == 2'b00 && !standby));

    // R3: a lane is driven only in read mode
    assert_drive_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (drv != 2'b00) |-> (mode == MODE_READ));

    // R6: write mode keeps the data pins released
    assert_write_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_WRITE) |-> (drv == 2'b00));

    // R5: strobes fire only in the sample right after a window
    assert_strobe_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wstb != 2'b00) |-> ($past(mode) == MODE_WRITE && mode != MODE_WRITE));

    // R5: one strobe burst per window
    assert_strobe_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wstb != 2'b00) |=> (wstb == 2'b00));

endmodule

bind lane_ram_ctrl lrc_checker i_lrc_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode_o),
    .standby (standby_o),
    .drv     ({drv_hi_o, drv_lo_o}),
    .wstb    (wstb)
);

// File: tb/test_lane_ram_ctrl.sv
module test_lane_ram_ctrl;

    localparam int CLK_P = 10;
    localparam int DEPTH = 1024;
    localparam int AW    = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_n = 1'b1, sel = 1'b0, oe_n = 1'b1, we_n = 1'b1;
    logic          lo_n = 1'b1, hi_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic          drv_lo, drv_hi, standby;
    logic [1:0]    mode;

    lane_ram_ctrl #(.DEPTH(DEPTH)) i_lane_ram_ctrl (
        .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .sel_i(sel), .oe_n_i(oe_n),
        .we_n_i(we_n), .lo_en_n_i(lo_n), .hi_en_n_i(hi_n), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .drv_lo_o(drv_lo), .drv_hi_o(drv_hi),
        .standby_o(standby), .mode_o(mode)
    );

    always #(CLK_P/2) clk = ~clk;

    typedef struct {
        logic [1:0]  m;
        logic        s;
        logic [1:0]  d;
        logic [15:0] r;
        string       tag;
    } exp_t;

    exp_t        q[$];
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    // Requirement model
    bit [15:0]     refm [DEPTH];
    bit            pend_v = 1'b0;
    bit [AW-1:0]   pend_a;
    bit [15:0]     pend_d;
    bit [1:0]      pend_l;

    task automatic put(input logic sn, input logic s, input logic oen, input logic wen,
                       input logic lon, input logic hin, input logic [AW-1:0] a,
                       input logic [15:0] d, input string tag);
        exp_t e;
        bit   selx, wa;
        @(negedge clk);
        sel_n = sn; sel = s; oe_n = oen; we_n = wen; lo_n = lon; hi_n = hin;
        addr = a; wdata = d;
        selx = !sn && s && !(lon && hin);
        e.tag = tag;
        e.d = 2'b00;
        e.r = 16'h0000;
        if (!selx) begin
            e.m = 2'd0; e.s = 1'b1;
        end else if (!wen) begin
            e.m = 2'd3; e.s = 1'b0;
        end else if (!oen) begin
            e.m = 2'd2; e.s = 1'b0;
            e.d = {!hin, !lon};
            if (!lon) e.r[7:0]  = refm[a][7:0];
            if (!hin) e.r[15:8] = refm[a][15:8];
        end else begin
            e.m = 2'd1; e.s = 1'b0;
        end
        q.push_back(e);
        wa = selx && !wen;
        if (pend_v && !wa) begin
            if (pend_l[0]) refm[pend_a][7:0]  = pend_d[7:0];
            if (pend_l[1]) refm[pend_a][15:8] = pend_d[15:8];
            pend_v = 1'b0;
        end
        if (wa) begin
            pend_v = 1'b1; pend_a = a; pend_d = d; pend_l = {!hin, !lon};
        end
    endtask

    task automatic wr_word(input logic [AW-1:0] a, input logic [15:0] d, input string tag);
        put(0, 1, 1, 0, 0, 0, a, d, tag);
        put(0, 1, 1, 1, 0, 0, a, 16'h0, tag);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic lon, input logic hin, input string tag);
        put(0, 1, 0, 1, lon, hin, a, 16'h0, tag);
    endtask

    // Monitor: checks each item one edge after it was driven
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (mode !== e.m || standby !== e.s || {drv_hi, drv_lo} !== e.d || rdata !== e.r) begin
                    errors++;
                    $display("FAIL %s: mode=%0d stby=%0b drv=%b rdata=%h, expected mode=%0d stby=%0b drv=%b rdata=%h",
                             e.tag, mode, standby, {drv_hi, drv_lo}, rdata, e.m, e.s, e.d, e.r);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state, checked before release
        checks++;
        if (standby !== 1'b1 || mode !== 2'd0 || drv_lo !== 1'b0 || drv_hi !== 1'b0) begin
            errors++;
            $display("FAIL R7 reset: mode=%0d stby=%0b, expected mode=0 stby=1", mode, standby);
        end
        rst_n = 1'b1;
        put(1, 0, 1, 1, 1, 1, 0, 0, "R7 idle after reset");

        // Word write then reads per lane
        put(0, 1, 1, 0, 0, 0, 5, 16'h1234, "R6 write window");
        put(0, 1, 1, 1, 0, 0, 5, 16'h0, "R2 output disabled after write");
        rd(5, 0, 0, "R3 word read");
        rd(5, 0, 1, "R3 lower read");
        rd(5, 1, 0, "R3 upper read");
        put(0, 1, 1, 1, 0, 1, 5, 16'h0, "R2 output disabled lower lane");

        // Lower-only write with output enable low, closing sample is a read
        put(0, 1, 0, 0, 0, 1, 5, 16'hABCD, "R6 no drive with oe low");
        rd(5, 0, 0, "R5 closing sample shows old word");
        rd(5, 0, 0, "R4 lower lane only written");

        // Upper-only write
        wr_word(6, 16'h5566, "R4 preset addr 6");
        put(0, 1, 1, 0, 1, 0, 6, 16'h99FF, "R4 upper window");
        put(0, 1, 1, 1, 1, 0, 6, 16'h0, "R4 upper close");
        rd(6, 0, 0, "R4 upper lane only written");

        // Writes attempted in standby are ignored
        put(1, 1, 0, 0, 0, 0, 5, 16'hFFFF, "R1 low select inactive");
        put(0, 0, 0, 0, 0, 0, 5, 16'hFFFF, "R1 high select inactive");
        put(0, 1, 0, 0, 1, 1, 5, 16'hFFFF, "R1 both lanes off");
        rd(5, 0, 0, "R1 standby write ignored");

        // Data and address change within one window, closed by the low select
        wr_word(7, 16'h0F0F, "R5 preset addr 7");
        put(0, 1, 1, 0, 0, 0, 7, 16'h1111, "R5 window first");
        put(0, 1, 1, 0, 0, 0, 7, 16'h2222, "R5 window second");
        put(0, 1, 1, 0, 0, 0, 8, 16'h3333, "R5 window last");
        put(1, 1, 1, 1, 0, 0, 8, 16'h0, "R1 close by select");
        rd(8, 0, 0, "R5 last address and data stored");
        rd(7, 0, 0, "R5 earlier address untouched");

        // Closed by the high select going low
        put(0, 1, 1, 0, 0, 0, 9, 16'h5A5A, "R6 window");
        put(0, 0, 1, 0, 0, 0, 9, 16'h0, "R1 close by high select");
        rd(9, 0, 0, "R5 close by high select stored");

        // Closed by both lanes going inactive
        wr_word(10, 16'h7777, "R5 preset addr 10");
        put(0, 1, 1, 0, 0, 1, 10, 16'h00AA, "R6 lower window");
        put(0, 1, 1, 0, 1, 1, 10, 16'hFFFF, "R1 close by lanes");
        rd(10, 0, 0, "R5 close by lanes stored lower");

        // Lane set changes inside a window: last sample decides
        wr_word(11, 16'h4444, "R4 preset addr 11");
        put(0, 1, 1, 0, 0, 0, 11, 16'h1111, "R4 window both lanes");
        put(0, 1, 0, 0, 1, 0, 11, 16'h2222, "R4 window upper only");
        rd(11, 0, 0, "R5 closing read old");
        rd(11, 0, 0, "R4 last lane set used");

        // Back-to-back windows
        put(0, 1, 1, 0, 0, 0, 12, 16'hC0DE, "R6 window A");
        put(0, 1, 1, 1, 0, 0, 12, 16'h0, "R2 gap");
        put(0, 1, 1, 0, 0, 0, 13, 16'hBEEF, "R6 window B");
        put(1, 0, 1, 1, 1, 1, 13, 16'h0, "R1 idle");
        rd(12, 0, 0, "R5 first window stored");
        rd(13, 0, 0, "R5 second window stored");
        put(1, 0, 1, 1, 1, 1, 0, 0, "R1 final standby");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule